// File: doc/BRIEF.md
# Iterative Waveform Update Controller

This block paces a digital-to-analog output through a stored waveform. A software start arms it, and a trigger strobe then begins generation, either at once or after a programmable start delay. While it runs, an interval counter divides the clock into a regular update strobe. On each strobe the block presents the buffer index of the sample to convert. After the last sample of the waveform the index returns to zero.

A waveform holds a programmed number of samples and repeats a programmed number of times, or without end. In re-trigger mode a completed run returns to the armed state, and the next trigger starts a fresh run. A software stop ends generation in one of three ways: at once, at the end of the current waveform, or at the end of the current group of iterations.

Top module: `wave_iter_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `genBusy`, `updStrobe` and `sampleAddr` are all zero until a run begins.
- R2: During a run, `updStrobe` is high in the first running cycle and then once every `updInterval` clocks.
- R3: On successive strobes, `sampleAddr` steps 0, 1, ... `updCount`-1 and then returns to 0. It reads 0 whenever `genBusy` is low.
- R4: With `iterInfinite` low, a run gives exactly `updCount` x `iterCount` strobes. `genBusy` falls in the cycle after the last of them.
- R5: With `iterInfinite` high, the waveform repeats until a stop command ends it.
- R6: A trigger arriving after `swStart` with `startDelay` = 0 makes `genBusy` and `updStrobe` high, with `sampleAddr` = 0, in the next cycle. A trigger is ignored while the block is idle or busy.
- R7: With `startDelay` = D > 0, `genBusy` rises one cycle after the trigger, and the first strobe comes D cycles later than it would with D = 0.
- R8: With `retrigEn` high, a run that completes all its iterations returns to the armed state with `genBusy` low, and a later trigger starts a new run from address 0.
- R9: Stop mode codes 0 and 3 are immediate: `genBusy` and `sampleAddr` read 0 in the cycle after `swStop`.
- R10: Stop mode code 1 lets the current waveform finish. The run ends after a strobe at address `updCount`-1.
- R11: Stop mode code 2 lets the current group of `iterCount` waveforms finish. In infinite mode the total strobe count is then a multiple of `updCount` x `iterCount`.
- R12: A stop while armed or in the start delay returns the block to idle at once. A later trigger then has no effect, and `swStart` is ignored while the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base for update intervals |
| rstN | input | 1 | Asynchronous reset, active low |
| swStart | input | 1 | Software start pulse; arms the block when idle |
| swStop | input | 1 | Software stop pulse; handled according to `stopMode` |
| trigIn | input | 1 | Trigger strobe; starts a run when the block is armed |
| updInterval | input | UI_W | Clocks between update strobes |
| updCount | input | ADDR_W+1 | Samples per waveform |
| iterCount | input | IC_W | Waveforms per run, or per stop group when infinite |
| iterInfinite | input | 1 | Repeat the waveform until stopped |
| retrigEn | input | 1 | Re-arm after each completed run |
| startDelay | input | DLY_W | Clocks from trigger to the first running cycle |
| stopMode | input | 2 | 0/3 immediate, 1 end of waveform, 2 end of group |
| sampleAddr | output | ADDR_W | Buffer index of the sample for the current strobe |
| updStrobe | output | 1 | Update strobe, one clock wide |
| genBusy | output | 1 | High during the start delay and during generation |

## Verification
The bench builds the block with a 3-bit address, 6-bit interval, 3-bit iteration and 4-bit delay counter. With these sizes, complete waveforms, iteration groups and delays all fit into a few dozen cycles. The short intervals (1 to 3) and sample counts (3 to 5) make address wraps, group boundaries and stop commands that land mid-waveform happen often. The bench can therefore place each stop mode against a known position in the sequence.

// File: rtl/wave_iter_pkg.sv
package wave_iter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } wiStateT;

  // strobes from the sequencer to the counters
  typedef struct packed {
    logic run;      // state is RUN this cycle
    logic hold;     // state stays RUN into the next cycle
    logic loadDly;  // load the start-delay counter
    logic tickDly;  // count the start delay down
  } wiCtlT;

  // status from the counters back to the sequencer
  typedef struct packed {
    logic strobe;   // update strobe this cycle
    logic wfEnd;    // strobe on the last sample of a waveform
    logic grpEnd;   // waveform end that also closes an iteration group
    logic dlyDone;  // start delay counter is at zero
  } wiFlagT;

  localparam logic [1:0] STOP_NOW   = 2'd0;
  localparam logic [1:0] STOP_WAVE  = 2'd1;
  localparam logic [1:0] STOP_GROUP = 2'd2;

endpackage

// File: rtl/wave_iter_cnt.sv
module wave_iter_cnt
  import wave_iter_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int UI_W   = 24,
  parameter int IC_W   = 16,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wiCtlT             ctl,
  input  logic [UI_W-1:0]   updInterval,
  input  logic [ADDR_W:0]   updCount,
  input  logic [IC_W-1:0]   iterCount,
  input  logic [DLY_W-1:0]  startDelay,
  output wiFlagT            flags,
  output logic [ADDR_W-1:0] sampleAddr
);

  logic [ADDR_W:0]   countM1;
  logic [ADDR_W-1:0] lastAddr;
  logic [UI_W-1:0]   lastIv;
  logic [IC_W-1:0]   lastIt;

  logic [UI_W-1:0]   ivCnt;
  logic [ADDR_W-1:0] addrCnt;
  logic [IC_W-1:0]   itCnt;
  logic [DLY_W-1:0]  dlyCnt;

  // programmed values of zero behave as one
  always_comb begin
    countM1  = (updCount == '0) ? '0 : updCount - 1'b1;
    lastAddr = countM1[ADDR_W] ? '1 : countM1[ADDR_W-1:0];
    lastIv   = (updInterval == '0) ? '0 : updInterval - 1'b1;
    lastIt   = (iterCount == '0) ? '0 : iterCount - 1'b1;
  end

  always_comb begin
    flags.strobe  = ctl.run && (ivCnt == '0);
    flags.wfEnd   = flags.strobe && (addrCnt == lastAddr);
    flags.grpEnd  = flags.wfEnd && (itCnt == lastIt);
    flags.dlyDone = (dlyCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivCnt   <= '0;
      addrCnt <= '0;
      itCnt   <= '0;
    end else if (!ctl.hold) begin
      ivCnt   <= '0;
      addrCnt <= '0;
      itCnt   <= '0;
    end else begin
      ivCnt <= (ivCnt == '0) ? lastIv : ivCnt - 1'b1;
      if (flags.strobe) addrCnt <= flags.wfEnd ? '0 : addrCnt + 1'b1;
      if (flags.wfEnd)  itCnt   <= flags.grpEnd ? '0 : itCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           dlyCnt <= '0;
    else if (ctl.loadDly)                dlyCnt <= startDelay - 1'b1;
    else if (ctl.tickDly && !flags.dlyDone) dlyCnt <= dlyCnt - 1'b1;
  end

  assign sampleAddr = addrCnt;

endmodule

// File: rtl/wave_iter_seq.sv
module wave_iter_seq
  import wave_iter_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swStart,
  input  logic             swStop,
  input  logic             trigIn,
  input  logic             iterInfinite,
  input  logic             retrigEn,
  input  logic [DLY_W-1:0] startDelay,
  input  logic [1:0]       stopMode,
  input  wiFlagT           flags,
  output wiCtlT            ctl,
  output logic             genBusy
);

  wiStateT state, nxt;
  logic    stopPend;
  logic    stopNow, stopReq;

  always_comb begin
    stopNow = swStop && ((stopMode == STOP_NOW) || (stopMode == 2'd3));
    stopReq = stopPend || swStop;
    nxt     = state;
    unique case (state)
      ST_IDLE:  if (swStart) nxt = ST_ARMED;
      ST_ARMED: begin
        if (swStop)      nxt = ST_IDLE;
        else if (trigIn) nxt = (startDelay == '0) ? ST_RUN : ST_DELAY;
      end
      ST_DELAY: begin
        if (swStop)             nxt = ST_IDLE;
        else if (flags.dlyDone) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (stopNow)
          nxt = ST_IDLE;
        else if (flags.grpEnd && !iterInfinite)
          nxt = (retrigEn && !stopReq) ? ST_ARMED : ST_IDLE;
        else if (flags.wfEnd && stopReq && stopMode == STOP_WAVE)
          nxt = ST_IDLE;
        else if (flags.grpEnd && stopReq && stopMode == STOP_GROUP)
          nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.run     = (state == ST_RUN);
    ctl.hold    = (state == ST_RUN) && (nxt == ST_RUN);
    ctl.loadDly = (state == ST_ARMED) && (nxt == ST_DELAY);
    ctl.tickDly = (state == ST_DELAY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stopPend <= 1'b0;
    end else begin
      state <= nxt;
      if (!ctl.hold)  stopPend <= 1'b0;
      else if (swStop) stopPend <= 1'b1;
    end
  end

  assign genBusy = (state == ST_DELAY) || (state == ST_RUN);

endmodule

// File: rtl/wave_iter_ctrl.sv
module wave_iter_ctrl
  import wave_iter_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int UI_W   = 24,
  parameter int IC_W   = 16,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swStart,
  input  logic              swStop,
  input  logic              trigIn,
  input  logic [UI_W-1:0]   updInterval,
  input  logic [ADDR_W:0]   updCount,
  input  logic [IC_W-1:0]   iterCount,
  input  logic              iterInfinite,
  input  logic              retrigEn,
  input  logic [DLY_W-1:0]  startDelay,
  input  logic [1:0]        stopMode,
  output logic [ADDR_W-1:0] sampleAddr,
  output logic              updStrobe,
  output logic              genBusy
);

  wiCtlT  ctl;
  wiFlagT flags;

  wave_iter_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rstN(rstN), .swStart(swStart), .swStop(swStop),
    .trigIn(trigIn), .iterInfinite(iterInfinite), .retrigEn(retrigEn),
    .startDelay(startDelay), .stopMode(stopMode), .flags(flags),
    .ctl(ctl), .genBusy(genBusy)
  );

  wave_iter_cnt #(.ADDR_W(ADDR_W), .UI_W(UI_W), .IC_W(IC_W), .DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rstN(rstN), .ctl(ctl), .updInterval(updInterval),
    .updCount(updCount), .iterCount(iterCount), .startDelay(startDelay),
    .flags(flags), .sampleAddr(sampleAddr)
  );

  assign updStrobe = flags.strobe;

endmodule

// File: rtl/wave_iter_chk.sv
module wave_iter_chk #(
  parameter int ADDR_W = 12,
  parameter int UI_W   = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              swStop,
  input logic              trigIn,
  input logic [UI_W-1:0]   updInterval,
  input logic [ADDR_W:0]   updCount,
  input logic [ADDR_W-1:0] sampleAddr,
  input logic              updStrobe,
  input logic              genBusy
);

  p_idle_addr_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !genBusy |-> sampleAddr == '0);

  p_addr_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (genBusy && updCount != '0) |-> ({1'b0, sampleAddr} < updCount));

  p_strobe_needs_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> genBusy);

  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && updInterval > 1) |=> !updStrobe);

  p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(genBusy) |-> ($past(updStrobe) || $past(swStop)));

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(genBusy) |-> $past(trigIn));

endmodule

bind wave_iter_ctrl wave_iter_chk #(.ADDR_W(ADDR_W), .UI_W(UI_W)) u_chk (
  .clk(clk), .rstN(rstN), .swStop(swStop), .trigIn(trigIn),
  .updInterval(updInterval), .updCount(updCount), .sampleAddr(sampleAddr),
  .updStrobe(updStrobe), .genBusy(genBusy)
);

// File: tb/wave_iter_ctrl_bench.sv
module wave_iter_ctrl_bench;
  localparam int AW = 3;
  localparam int UW = 6;
  localparam int IW = 3;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swStart = 0, swStop = 0, trigIn = 0;
  logic [UW-1:0] updInterval = 1;
  logic [AW:0]   updCount = 1;
  logic [IW-1:0] iterCount = 1;
  logic          iterInfinite = 0, retrigEn = 0;
  logic [DW-1:0] startDelay = 0;
  logic [1:0]    stopMode = 0;
  logic [AW-1:0] sampleAddr;
  logic          updStrobe, genBusy;

  always #5 clk = ~clk;

  wave_iter_ctrl #(.ADDR_W(AW), .UI_W(UW), .IC_W(IW), .DLY_W(DW)) u_wave_iter_ctrl (
    .clk(clk), .rstN(rstN), .swStart(swStart), .swStop(swStop), .trigIn(trigIn),
    .updInterval(updInterval), .updCount(updCount), .iterCount(iterCount),
    .iterInfinite(iterInfinite), .retrigEn(retrigEn), .startDelay(startDelay),
    .stopMode(stopMode), .sampleAddr(sampleAddr), .updStrobe(updStrobe),
    .genBusy(genBusy)
  );

  int    checks = 0, failures = 0, strobeSeen = 0;
  string curReq = "R1";
  bit    cmpEn = 0;

  // behavioural reference: 0 idle, 1 armed, 2 delay, 3 run
  int mSt = 0, mIv = 0, mAddr = 0, mIt = 0, mDly = 0, mNxt = 0;
  int la = 0, li = 0, lv = 0, nSamp = 0;
  bit mPend = 0, stb = 0, wf = 0, grp = 0, req = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mIv = 0; mAddr = 0; mIt = 0; mDly = 0; mPend = 0;
    end else begin
      nSamp = (updCount == 0) ? 1 : int'(updCount);
      if (nSamp > (1 << AW)) nSamp = 1 << AW;
      la = nSamp - 1;
      li = (iterCount == 0) ? 0 : int'(iterCount) - 1;
      lv = (updInterval == 0) ? 0 : int'(updInterval) - 1;
      case (mSt)
        0: if (swStart) mSt = 1;
        1: if (swStop) mSt = 0;
           else if (trigIn) begin
             if (startDelay == 0) mSt = 3;
             else begin mSt = 2; mDly = int'(startDelay) - 1; end
           end
        2: if (swStop) mSt = 0;
           else if (mDly == 0) mSt = 3;
           else mDly = mDly - 1;
        default: begin
          stb = (mIv == 0);
          wf  = stb && (mAddr == la);
          grp = wf && (mIt == li);
          req = mPend || swStop;
          mNxt = 3;
          if (swStop && (stopMode == 0 || stopMode == 3)) mNxt = 0;
          else if (grp && !iterInfinite) mNxt = (retrigEn && !req) ? 1 : 0;
          else if (wf && req && stopMode == 1) mNxt = 0;
          else if (grp && req && stopMode == 2) mNxt = 0;
          if (mNxt != 3) begin
            mSt = mNxt; mIv = 0; mAddr = 0; mIt = 0; mPend = 0;
          end else begin
            if (swStop) mPend = 1;
            if (stb) begin
              mAddr = wf ? 0 : mAddr + 1;
              if (wf) mIt = grp ? 0 : mIt + 1;
            end
            mIv = stb ? lv : mIv - 1;
          end
        end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmpEn) begin
      checks++;
      if (updStrobe) strobeSeen++;
      if (genBusy !== (mSt >= 2) || updStrobe !== (mSt == 3 && mIv == 0) ||
          int'(sampleAddr) != mAddr) begin
        failures++;
        $display("FAIL %s model: busy=%0b strobe=%0b addr=%0d expected busy=%0b strobe=%0b addr=%0d",
                 curReq, genBusy, updStrobe, sampleAddr, (mSt >= 2), (mSt == 3 && mIv == 0), mAddr);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic doStart; @(negedge clk) swStart = 1; @(negedge clk) swStart = 0; endtask
  task automatic doStop;  @(negedge clk) swStop  = 1; @(negedge clk) swStop  = 0; endtask
  task automatic doTrig;  @(negedge clk) trigIn  = 1; @(negedge clk) trigIn  = 0; endtask

  task automatic setCfg(int iv, int cnt, int it, bit inf, bit rt, int dly, int sm);
    updInterval = UW'(iv); updCount = (AW+1)'(cnt); iterCount = IW'(it);
    iterInfinite = inf; retrigEn = rt; startDelay = DW'(dly); stopMode = 2'(sm);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(3);
    check("R1 busy", int'(genBusy), 0);
    check("R1 strobe", int'(updStrobe), 0);
    check("R1 addr", int'(sampleAddr), 0);
    rstN = 1;
    cmpEn = 1;
    tick(2);

    // R6, R2, R3, R4: finite run, post-trigger start
    setCfg(3, 4, 2, 0, 0, 0, 0);
    curReq = "R6";
    doTrig;
    tick(1);
    check("R6 trigger while idle", int'(genBusy), 0);
    doStart;
    tick(2);
    strobeSeen = 0;
    doTrig;
    check("R6 busy after trigger", int'(genBusy), 1);
    check("R6 strobe after trigger", int'(updStrobe), 1);
    check("R6 addr after trigger", int'(sampleAddr), 0);
    curReq = "R2";
    tick(3);
    doTrig;                      // ignored while busy
    curReq = "R3";
    tick(10);
    curReq = "R4";
    tick(25);
    check("R4 strobe total", strobeSeen, 8);
    check("R4 busy after run", int'(genBusy), 0);

    // R5, R9: infinite run, immediate stop with code 3
    setCfg(1, 5, 1, 1, 0, 0, 3);
    curReq = "R5";
    doStart;
    strobeSeen = 0;
    doTrig;
    tick(23);
    check("R5 keeps repeating", int'(strobeSeen > 5), 1);
    curReq = "R9";
    doStop;
    check("R9 busy after stop", int'(genBusy), 0);
    check("R9 addr after stop", int'(sampleAddr), 0);
    tick(3);

    // R7, R8, R12: start delay, re-trigger, stop while armed or delaying
    setCfg(2, 3, 1, 0, 1, 4, 0);
    curReq = "R7";
    doStart;
    doTrig;
    check("R7 busy in delay", int'(genBusy), 1);
    check("R7 no strobe in delay", int'(updStrobe), 0);
    tick(3);
    check("R7 still delaying", int'(updStrobe), 0);
    tick(1);
    check("R7 first strobe", int'(updStrobe), 1);
    curReq = "R8";
    tick(20);
    check("R8 re-armed idle", int'(genBusy), 0);
    doTrig;
    check("R8 second run starts", int'(genBusy), 1);
    tick(20);
    curReq = "R12";
    doStart;                     // ignored: already armed
    doStop;
    doTrig;
    tick(2);
    check("R12 trigger after stop", int'(genBusy), 0);
    doStart;
    doTrig;
    tick(1);
    doStop;
    check("R12 stop in delay", int'(genBusy), 0);
    tick(3);

    // R10: stop at end of waveform
    setCfg(2, 4, 1, 1, 0, 0, 1);
    curReq = "R10";
    doStart;
    strobeSeen = 0;
    doTrig;
    tick(3);
    doStop;
    tick(1);
    check("R10 finishing waveform", int'(genBusy), 1);
    tick(20);
    check("R10 stopped", int'(genBusy), 0);
    check("R10 whole waveforms", strobeSeen, 4);

    // R11: stop at end of iteration group, infinite mode
    setCfg(1, 3, 2, 1, 0, 0, 2);
    curReq = "R11";
    doStart;
    strobeSeen = 0;
    doTrig;
    tick(8);
    doStop;
    tick(30);
    check("R11 stopped", int'(genBusy), 0);
    check("R11 strobe total", strobeSeen, 12);

    cmpEn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule